// File: doc/BRIEF.md
# PLL Reference Mode Controller

This block decides the operating mode of a digital phase-locked loop. It has four modes: free-run, lock acquisition, normal (locked) and holdover. Its inputs are one qualification flag per reference candidate, a flag saying the reference monitors have finished evaluating the candidates, a phase-lock indication from the loop, and a manual mode override. The block picks the reference the loop tracks, moves between modes on its own, and fails over to another qualified reference when the tracked one drops out.

While the loop is locked, the block keeps a running exponential average of the loop's frequency control word. In holdover it drives that frozen average out in place of the live control word, so the loop keeps producing the last trusted frequency. All outputs are registered. The mode and the selected index change on the edge that samples the cause. The lock flag, the holdover flag and the control word output follow one cycle after that.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While `rst` is high, and on the edge after it, `mode` is free-run, `sel_ref` is 0, `lock_flag` and `holdover_flag` are 0 and `cw_out` is 0. The mode codes are 0 free-run, 1 lock acquisition, 2 normal and 3 holdover.
- R2: In free-run, the mode moves to lock acquisition only on an edge where `eval_done` is 1 and at least one `ref_qual` bit is set. At that edge `sel_ref` becomes the lowest qualified index. Otherwise the mode stays free-run.
- R3: In lock acquisition, if `phase_lock` is 1 and the selected reference is still qualified, the next mode is normal.
- R4: In normal mode, if the selected reference loses qualification and another reference is qualified, the next mode is lock acquisition. `sel_ref` becomes the lowest qualified index other than the failed one.
- R5: In normal mode, if the selected reference loses qualification and no other reference is qualified, the next mode is holdover.
- R6: In holdover, when any reference is qualified, the next mode is lock acquisition and `sel_ref` becomes the lowest qualified index.
- R7: In lock acquisition, if the selected reference loses qualification, the block reselects the lowest other qualified reference and stays in lock acquisition. If no other reference is qualified, it goes to holdover when normal mode has been reached since reset, and to free-run when it has not.
- R8: The frequency average changes only on edges where the mode is normal. On the first such edge since reset it loads `cw_in`. On later such edges it adds (`cw_in` − average) arithmetically shifted right by `AVG_SHIFT`.
- R9: `cw_out` is the previous cycle's `cw_in`, except when the previous cycle's mode was holdover. In that case it is the stored average.
- R10: `lock_flag` is 1 exactly when the previous cycle's mode was normal. `holdover_flag` is 1 exactly when the previous cycle's mode was holdover.
- R11: When `manual_en` is 1, the next mode is `manual_mode` (same codes as R1) and `sel_ref` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_qual | input | NUM_REFS | Per-reference qualification flags from the monitors |
| eval_done | input | 1 | All references have been evaluated |
| phase_lock | input | 1 | Loop reports phase lock on the selected reference |
| manual_en | input | 1 | Use the manual mode instead of the automatic machine |
| manual_mode | input | 2 | Forced mode code |
| cw_in | input | CW_W | Live frequency control word from the loop filter |
| mode | output | 2 | Current mode code |
| sel_ref | output | $clog2(NUM_REFS) | Index of the selected reference |
| lock_flag | output | 1 | Registered locked status |
| holdover_flag | output | 1 | Registered holdover status |
| cw_out | output | CW_W | Control word driven to the oscillator |

## Verification
The assertions assume that `ref_qual`, `eval_done`, `phase_lock` and the manual controls are synchronous to `clk` and hold steady around each rising edge. They also assume that `sel_ref` always indexes a real reference. The bench changes every input just after a falling edge and uses only the default eight-reference size, so both assumptions hold. The stimulus walks each mode transition on purpose: failover from normal and from acquisition, loss of all references with and without a prior lock, and manual forcing. This lets the behavioural model and the property checks see every branch.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ACQ  = 2'd1,
    MODE_NORM = 2'd2,
    MODE_HOLD = 2'd3
  } pll_mode_e;
endpackage

// File: rtl/pll_ref_pick.sv
module pll_ref_pick #(
  parameter int NUM_REFS = 8,
  localparam int IDX_W = $clog2(NUM_REFS)
) (
  input  logic [NUM_REFS-1:0] qual,
  input  logic                excl_en,
  input  logic [IDX_W-1:0]    excl_idx,
  output logic                found,
  output logic [IDX_W-1:0]    idx
);
  logic [NUM_REFS-1:0] cand;

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_cand
    assign cand[g] = qual[g] && !(excl_en && (excl_idx == IDX_W'(g)));
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = NUM_REFS - 1; k >= 0; k--) begin
      if (cand[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end

  // R4: a picked index is qualified and never the excluded one
  always_comb begin
    a_r4_pick_valid: assert (!found || (qual[idx] && !(excl_en && idx == excl_idx)));
  end
endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
#(
  parameter int NUM_REFS = 8,
  localparam int IDX_W = $clog2(NUM_REFS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REFS-1:0] ref_qual,
  input  logic                eval_done,
  input  logic                phase_lock,
  input  logic                manual_en,
  input  logic [1:0]          manual_mode,
  output pll_mode_e           state,
  output logic [IDX_W-1:0]    sel,
  output logic                synced
);
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             excl_en;
  logic             sel_ok;
  pll_mode_e        state_n;
  logic [IDX_W-1:0] sel_n;

  assign excl_en = (state == MODE_ACQ) || (state == MODE_NORM);
  assign sel_ok  = ref_qual[sel];

  pll_ref_pick #(.NUM_REFS(NUM_REFS)) u_pick (
    .qual     (ref_qual),
    .excl_en  (excl_en),
    .excl_idx (sel),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  always_comb begin
    state_n = state;
    sel_n   = sel;
    if (manual_en) begin
      state_n = pll_mode_e'(manual_mode);
    end else begin
      case (state)
        MODE_FREE: if (eval_done && pick_found) begin
          state_n = MODE_ACQ;
          sel_n   = pick_idx;
        end
        MODE_ACQ: begin
          if (!sel_ok) begin
            if (pick_found) sel_n = pick_idx;
            else state_n = synced ? MODE_HOLD : MODE_FREE;
          end else if (phase_lock) begin
            state_n = MODE_NORM;
          end
        end
        MODE_NORM: if (!sel_ok) begin
          if (pick_found) begin
            state_n = MODE_ACQ;
            sel_n   = pick_idx;
          end else begin
            state_n = MODE_HOLD;
          end
        end
        default: if (pick_found) begin
          state_n = MODE_ACQ;
          sel_n   = pick_idx;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= MODE_FREE;
      sel    <= '0;
      synced <= 1'b0;
    end else begin
      state  <= state_n;
      sel    <= sel_n;
      synced <= synced || (state == MODE_NORM);
    end
  end

  a_r2_free_waits: assert property (@(posedge clk) disable iff (rst)
    (!manual_en && state == MODE_FREE && !(eval_done && |ref_qual)) |=> state == MODE_FREE);
  a_r3_acq_to_norm: assert property (@(posedge clk) disable iff (rst)
    (!manual_en && state == MODE_ACQ && phase_lock && ref_qual[sel]) |=> state == MODE_NORM);
  a_r4_failover: assert property (@(posedge clk) disable iff (rst)
    (!manual_en && state == MODE_NORM && !ref_qual[sel] && |(ref_qual & ~(NUM_REFS'(1) << sel)))
    |=> (state == MODE_ACQ && sel != $past(sel)));
  a_r5_to_hold: assert property (@(posedge clk) disable iff (rst)
    (!manual_en && state == MODE_NORM && ref_qual == '0) |=> state == MODE_HOLD);
  a_r11_manual: assert property (@(posedge clk) disable iff (rst)
    manual_en |=> (state == $past(manual_mode) && $stable(sel)));
endmodule

// File: rtl/pll_freq_avg.sv
module pll_freq_avg #(
  parameter int CW_W      = 24,
  parameter int AVG_SHIFT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_en,
  input  logic            seed,
  input  logic [CW_W-1:0] cw_in,
  output logic [CW_W-1:0] avg_q
);
  logic signed [CW_W:0] diff;
  logic signed [CW_W:0] step;

  assign diff = $signed({1'b0, cw_in}) - $signed({1'b0, avg_q});
  assign step = diff >>> AVG_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_q <= '0;
    end else if (upd_en) begin
      avg_q <= seed ? cw_in : avg_q + CW_W'(step);
    end
  end

  // R8: the average holds whenever no update is enabled
  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(avg_q));
  a_r8_seed: assert property (@(posedge clk) disable iff (rst)
    (upd_en && seed) |=> avg_q == $past(cw_in));
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
#(
  parameter int NUM_REFS  = 8,
  parameter int CW_W      = 24,
  parameter int AVG_SHIFT = 4,
  localparam int IDX_W = $clog2(NUM_REFS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REFS-1:0] ref_qual,
  input  logic                eval_done,
  input  logic                phase_lock,
  input  logic                manual_en,
  input  logic [1:0]          manual_mode,
  input  logic [CW_W-1:0]     cw_in,
  output logic [1:0]          mode,
  output logic [IDX_W-1:0]    sel_ref,
  output logic                lock_flag,
  output logic                holdover_flag,
  output logic [CW_W-1:0]     cw_out
);
  pll_mode_e       state;
  logic            synced;
  logic [CW_W-1:0] avg;

  pll_mode_fsm #(.NUM_REFS(NUM_REFS)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ref_qual    (ref_qual),
    .eval_done   (eval_done),
    .phase_lock  (phase_lock),
    .manual_en   (manual_en),
    .manual_mode (manual_mode),
    .state       (state),
    .sel         (sel_ref),
    .synced      (synced)
  );

  pll_freq_avg #(.CW_W(CW_W), .AVG_SHIFT(AVG_SHIFT)) u_avg (
    .clk    (clk),
    .rst    (rst),
    .upd_en (state == MODE_NORM),
    .seed   (!synced),
    .cw_in  (cw_in),
    .avg_q  (avg)
  );

  assign mode = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_flag     <= 1'b0;
      holdover_flag <= 1'b0;
      cw_out        <= '0;
    end else begin
      lock_flag     <= (state == MODE_NORM);
      holdover_flag <= (state == MODE_HOLD);
      cw_out        <= (state == MODE_HOLD) ? avg : cw_in;
    end
  end

  a_r10_lock_follows: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_flag) |-> $past(mode) == MODE_NORM);
  a_r10_one_flag: assert property (@(posedge clk) disable iff (rst)
    !(lock_flag && holdover_flag));
  a_r9_hold_output: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD) |=> cw_out == $past(avg));
endmodule

// File: tb/pll_mode_ctrl_tb.sv
module pll_mode_ctrl_tb;
  localparam int PERIOD = 10;
  localparam int NREF   = 8;
  localparam int CWW    = 24;
  localparam int SHIFT  = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NREF-1:0] ref_qual = '0;
  logic            eval_done = 1'b0;
  logic            phase_lock = 1'b0;
  logic            manual_en = 1'b0;
  logic [1:0]      manual_mode = 2'd0;
  logic [CWW-1:0]  cw_in = '0;
  logic [1:0]      mode;
  logic [2:0]      sel_ref;
  logic            lock_flag;
  logic            holdover_flag;
  logic [CWW-1:0]  cw_out;

  int total = 0;
  int bad = 0;
  bit armed = 0;
  bit done = 0;

  int m_state, m_sel, m_synced, m_avg, m_cwo, m_lock, m_hold;

  always #(PERIOD/2) clk = ~clk;

  pll_mode_ctrl u_dut (
    .clk(clk), .rst(rst), .ref_qual(ref_qual), .eval_done(eval_done),
    .phase_lock(phase_lock), .manual_en(manual_en), .manual_mode(manual_mode),
    .cw_in(cw_in), .mode(mode), .sel_ref(sel_ref), .lock_flag(lock_flag),
    .holdover_flag(holdover_flag), .cw_out(cw_out)
  );

  function automatic int pick(input logic [NREF-1:0] q, input int excl);
    for (int k = 0; k < NREF; k++) if (q[k] && k != excl) return k;
    return -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_sel = 0; m_synced = 0; m_avg = 0; m_cwo = 0; m_lock = 0; m_hold = 0;
      armed = 1;
    end else begin
      int ns, nsel, p;
      m_lock = (m_state == 2);
      m_hold = (m_state == 3);
      m_cwo  = (m_state == 3) ? m_avg : int'(cw_in);
      if (m_state == 2) m_avg = m_synced ? m_avg + ((int'(cw_in) - m_avg) >>> SHIFT) : int'(cw_in);
      ns = m_state; nsel = m_sel;
      if (manual_en) ns = int'(manual_mode);
      else begin
        p = pick(ref_qual, (m_state == 1 || m_state == 2) ? m_sel : -1);
        case (m_state)
          0: if (eval_done && p >= 0) begin ns = 1; nsel = p; end
          1: if (!ref_qual[m_sel]) begin
               if (p >= 0) nsel = p; else ns = m_synced ? 3 : 0;
             end else if (phase_lock) ns = 2;
          2: if (!ref_qual[m_sel]) begin
               if (p >= 0) begin ns = 1; nsel = p; end else ns = 3;
             end
          default: if (p >= 0) begin ns = 1; nsel = p; end
        endcase
      end
      if (m_state == 2) m_synced = 1;
      m_state = ns; m_sel = nsel;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      check("mode R2 R3 R4 R5 R6 R7 R11", int'(mode), m_state);
      check("sel_ref R4 R6 R7", int'(sel_ref), m_sel);
      check("lock_flag R10", int'(lock_flag), m_lock);
      check("holdover_flag R10", int'(holdover_flag), m_hold);
      check("cw_out R8 R9", int'(cw_out), m_cwo);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int held;
    cyc(2);
    check("R1 mode", int'(mode), 0);
    check("R1 lock_flag", int'(lock_flag), 0);
    check("R1 cw_out", int'(cw_out), 0);
    rst = 1'b0; cw_in = 24'h001000;
    cyc(1);
    check("R1 holdover_flag", int'(holdover_flag), 0);
    // R2: qualified but not evaluated
    ref_qual = 8'h10; cyc(2);
    check("R2 stays free", int'(mode), 0);
    eval_done = 1'b1; cyc(1);
    check("R2 to acq", int'(mode), 1);
    check("R2 lowest sel", int'(sel_ref), 4);
    // R7: fails before any lock -> free-run
    ref_qual = 8'h00; cyc(1);
    check("R7 back to free", int'(mode), 0);
    ref_qual = 8'h24; cyc(1);
    check("R2 sel two", int'(sel_ref), 2);
    phase_lock = 1'b1; cyc(1);
    check("R3 normal", int'(mode), 2);
    cyc(1);
    check("R10 lock set", int'(lock_flag), 1);
    for (int i = 0; i < 20; i++) begin
      cw_in = 24'h001000 + 24'(i * 24'h000357); cyc(1);
    end
    ref_qual = 8'h20; cyc(1);
    check("R4 failover mode", int'(mode), 1);
    check("R4 failover sel", int'(sel_ref), 5);
    cyc(1);
    check("R4 relock", int'(mode), 2);
    for (int i = 0; i < 8; i++) begin
      cw_in = 24'h00F000 - 24'(i * 24'h000111); cyc(1);
    end
    ref_qual = 8'h00; phase_lock = 1'b0; cyc(1);
    check("R5 holdover", int'(mode), 3);
    cyc(2);
    held = int'(cw_out);
    for (int i = 0; i < 6; i++) begin
      cw_in = 24'h800000 + 24'(i * 24'h001111); cyc(1);
    end
    check("R8 average frozen", int'(cw_out), held);
    ref_qual = 8'h81; cyc(1);
    check("R6 to acq", int'(mode), 1);
    check("R6 lowest sel", int'(sel_ref), 0);
    ref_qual = 8'h80; cyc(1);
    check("R7 reselect stays acq", int'(mode), 1);
    check("R7 reselect sel", int'(sel_ref), 7);
    ref_qual = 8'h00; cyc(1);
    check("R7 to holdover", int'(mode), 3);
    manual_en = 1'b1; manual_mode = 2'd2; cyc(1);
    check("R11 forced normal", int'(mode), 2);
    check("R11 sel kept", int'(sel_ref), 7);
    cyc(3);
    manual_mode = 2'd0; cyc(1);
    check("R11 forced free", int'(mode), 0);
    manual_en = 1'b0; cyc(3);
    check("R2 free no qual", int'(mode), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule